// File: doc/BRIEF.md
# ADC Controller Register Front End

This block is the bus-facing control layer of a successive-approximation ADC controller. Software reaches six word-aligned 32-bit registers through a simple bus with a valid strobe, a write flag, an address and write data. Read data comes back combinationally in the same cycle as the read strobe. Read side effects take place at the clock edge that ends the access.

Writing a channel number to the channel control register launches one conversion. A general control bit makes the converter run the same channel again and again. Another general control bit launches calibration. The converter itself sits outside the block. The block asks for a conversion or a calibration with one-cycle launch pulses and keeps `conv_active` high while the converter works. The converter answers with a one-cycle `conv_done` pulse. That pulse carries a 12-bit sample, left-justified at full precision, and a calibration failure flag.

The block shapes each sample to the selected resolution and latches it. It sets a completion flag and, if enabled, raises an interrupt. It also enforces the overwrite policy for results that software has not yet read.

Top module: `adc_ctrl_front`

## Requirements
- R1: After reset the status register (0x08), general control (0x18) and general status (0x1C) read 0. The channel control register (0x00) reads 0x1F. `irq`, `conv_start` and `conv_active` are low.
- R2: A write to 0x00 whose bits [4:0] are not 0x1F stores bits [4:0] as the channel and bit 7 as the interrupt enable. In the next cycle `conv_start` pulses high for exactly one cycle, `conv_chan` shows the new channel and `conv_active` is high.
- R3: A write to 0x00 with bits [4:0] = 0x1F stops the converter. No launch follows, `conv_active` drops in the next cycle, and any later `conv_done` leaves the status flag and the result untouched. A `conv_done` while idle is ignored in the same way.
- R4: A channel write while a conversion is in progress abandons it. The block relaunches with the new channel: `conv_start` pulses again and `conv_active` stays high.
- R5: On `conv_done` during a conversion, configuration bits [3:2] pick the result width: 00 is 8 bits, 01 is 10 bits, 10 or 11 is 12 bits. The block keeps that many top bits of the sample, right-aligned and zero-extended in the result register (0x0C). Status bit 0 becomes 1.
- R6: A read of the result register clears status bit 0 and so deasserts `irq`.
- R7: `irq` is high exactly when status bit 0 is set and channel control bit 7 is 1.
- R8: With configuration bit 16 at 0, a finished result is dropped while status bit 0 is still set, and the old result stays. With bit 16 at 1, the new result replaces the unread one.
- R9: While general control bit 6 is 1, each completed conversion is followed by a new launch of the same channel in the next cycle. Once the bit is 0, the conversion in progress is the last.
- R10: Writing general control bit 7 as 1 clears general status bit 1, pulses `cal_start` and keeps `conv_active` high. General control bit 7 reads 1 during calibration. At `conv_done`, bit 7 returns to 0, status bit 0 is set, and general status bit 1 takes the value of `conv_cal_fail`.
- R11: Reads at unimplemented or non-word-aligned addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is presented |
| conv_start | output | 1 | One-cycle conversion launch |
| cal_start | output | 1 | One-cycle calibration launch |
| conv_chan | output | 5 | Channel for the converter |
| conv_active | output | 1 | Conversion or calibration in progress |
| conv_done | input | 1 | One-cycle completion from the converter |
| conv_data | input | 12 | Full-precision sample, valid with `conv_done` |
| conv_cal_fail | input | 1 | Calibration failure, valid with `conv_done` |
| irq | output | 1 | Completion interrupt |

## Verification
A register write is taken at one rising edge. The resulting `conv_start` or `cal_start` pulse, the new `conv_chan` and `conv_active` appear after that edge and last exactly one cycle. The bench samples them at the falling edge that closes the write and checks at the next falling edge that the pulse has gone.

A `conv_done` pulse updates the result, status flag, general status and `irq` at the edge that samples it. In continuous mode it also starts the relaunch pulse at that edge. All of these are checked at the following falling edge.

Read data is combinational, so it is sampled in the middle of the read cycle. Clearing on read shows on the next access.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;

    localparam int OFS_CHAN_CTL = 'h00;
    localparam int OFS_STATUS   = 'h08;
    localparam int OFS_RESULT   = 'h0C;
    localparam int OFS_CONFIG   = 'h14;
    localparam int OFS_GEN_CTL  = 'h18;
    localparam int OFS_GEN_STAT = 'h1C;

    // bit positions the driver software depends on
    localparam int BIT_IRQ_EN   = 7;
    localparam int BIT_RES_LO   = 2;
    localparam int BIT_OVW_EN   = 16;
    localparam int BIT_CONT     = 6;
    localparam int BIT_CAL      = 7;
    localparam int BIT_CAL_FAIL = 1;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_CONV = 2'd1,
        SEQ_CAL  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic chan_ctl;
        logic status;
        logic result;
        logic config_r;
        logic gen_ctl;
        logic gen_stat;
    } reg_hit_t;

endpackage

// File: rtl/adcfe_decode.sv
module adcfe_decode
    import adcfe_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output reg_hit_t          hit,
    output logic              wr_en,
    output logic              rd_en
);

    always_comb begin
        hit = '0;
        if (addr[1:0] == 2'b00) begin
            case (addr)
                ADDR_W'(OFS_CHAN_CTL): hit.chan_ctl = 1'b1;
                ADDR_W'(OFS_STATUS):   hit.status   = 1'b1;
                ADDR_W'(OFS_RESULT):   hit.result   = 1'b1;
                ADDR_W'(OFS_CONFIG):   hit.config_r = 1'b1;
                ADDR_W'(OFS_GEN_CTL):  hit.gen_ctl  = 1'b1;
                ADDR_W'(OFS_GEN_STAT): hit.gen_stat = 1'b1;
                default: ;
            endcase
        end
        wr_en = valid && write;
        rd_en = valid && !write;
    end

endmodule

// File: rtl/adcfe_sequencer.sv
module adcfe_sequencer
    import adcfe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chan_wr,
    input  logic chan_stop,
    input  logic cal_wr,
    input  logic cont_en,
    input  logic conv_done,
    output logic conv_start,
    output logic cal_start,
    output logic active,
    output logic cal_active,
    output logic done_conv,
    output logic done_cal
);

    typedef struct packed {
        seq_state_e state;
        logic       start;
        logic       cal_start;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d           = seq_q;
        seq_d.start     = 1'b0;
        seq_d.cal_start = 1'b0;
        done_conv       = 1'b0;
        done_cal        = 1'b0;
        if (chan_wr) begin
            // a channel write always abandons whatever is running
            if (chan_stop) begin
                seq_d.state = SEQ_IDLE;
            end else begin
                seq_d.state = SEQ_CONV;
                seq_d.start = 1'b1;
            end
        end else if (cal_wr) begin
            seq_d.state     = SEQ_CAL;
            seq_d.cal_start = 1'b1;
        end else begin
            case (seq_q.state)
                SEQ_CONV: if (conv_done) begin
                    done_conv = 1'b1;
                    if (cont_en) seq_d.start = 1'b1;
                    else         seq_d.state = SEQ_IDLE;
                end
                SEQ_CAL: if (conv_done) begin
                    done_cal    = 1'b1;
                    seq_d.state = SEQ_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state     <= SEQ_IDLE;
            seq_q.start     <= 1'b0;
            seq_q.cal_start <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign conv_start = seq_q.start;
    assign cal_start  = seq_q.cal_start;
    assign active     = (seq_q.state != SEQ_IDLE);
    assign cal_active = (seq_q.state == SEQ_CAL);

endmodule

// File: rtl/adcfe_result.sv
module adcfe_result #(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                cal_flag,
    input  logic                rd_clear,
    input  logic                ovw_en,
    input  logic [1:0]          res_sel,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SAMPLE_W-1:0] value,
    output logic                flag
);

    localparam int SHIFT_8  = SAMPLE_W - 8;
    localparam int SHIFT_10 = SAMPLE_W - 10;

    typedef struct packed {
        logic [SAMPLE_W-1:0] value;
        logic                flag;
    } res_t;

    res_t res_d, res_q;
    logic [SAMPLE_W-1:0] shaped;

    always_comb begin
        case (res_sel)
            2'b00:   shaped = sample >> SHIFT_8;
            2'b01:   shaped = sample >> SHIFT_10;
            default: shaped = sample;
        endcase

        res_d = res_q;
        if (rd_clear) res_d.flag = 1'b0;
        // a result being read in this cycle counts as consumed
        if (capture && (!res_q.flag || ovw_en || rd_clear)) begin
            res_d.value = shaped;
            res_d.flag  = 1'b1;
        end
        if (cal_flag) res_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q.value <= '0;
            res_q.flag  <= 1'b0;
        end else begin
            res_q <= res_d;
        end
    end

    assign value = res_q.value;
    assign flag  = res_q.flag;

endmodule

// File: rtl/adc_ctrl_front.sv
module adc_ctrl_front
    import adcfe_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CHAN_W   = 5,
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                conv_start,
    output logic                cal_start,
    output logic [CHAN_W-1:0]   conv_chan,
    output logic                conv_active,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] conv_data,
    input  logic                conv_cal_fail,
    output logic                irq
);

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              irq_en;
        logic [1:0]        res;
        logic              ovw;
        logic              cont;
        logic              calf;
    } ctl_t;

    reg_hit_t            hit;
    logic                wr_en, rd_en;
    logic                chan_wr, chan_stop, cal_wr;
    logic                cal_active, done_conv, done_cal;
    logic [SAMPLE_W-1:0] res_value;
    logic                res_flag;
    logic                wdata_unused;
    ctl_t                ctl_d, ctl_q;

    adcfe_decode #(.ADDR_W(ADDR_W)) u_decode (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .hit   (hit),
        .wr_en (wr_en),
        .rd_en (rd_en)
    );

    assign chan_wr   = wr_en && hit.chan_ctl;
    assign chan_stop = (bus_wdata[CHAN_W-1:0] == '1);
    assign cal_wr    = wr_en && hit.gen_ctl && bus_wdata[BIT_CAL];
    assign wdata_unused = ^bus_wdata;

    adcfe_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_wr    (chan_wr),
        .chan_stop  (chan_stop),
        .cal_wr     (cal_wr),
        .cont_en    (ctl_q.cont),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .cal_start  (cal_start),
        .active     (conv_active),
        .cal_active (cal_active),
        .done_conv  (done_conv),
        .done_cal   (done_cal)
    );

    adcfe_result #(.SAMPLE_W(SAMPLE_W)) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (done_conv),
        .cal_flag (done_cal),
        .rd_clear (rd_en && hit.result),
        .ovw_en   (ctl_q.ovw),
        .res_sel  (ctl_q.res),
        .sample   (conv_data),
        .value    (res_value),
        .flag     (res_flag)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (chan_wr) begin
            ctl_d.chan   = bus_wdata[CHAN_W-1:0];
            ctl_d.irq_en = bus_wdata[BIT_IRQ_EN];
        end
        if (wr_en && hit.config_r) begin
            ctl_d.res = bus_wdata[BIT_RES_LO +: 2];
            ctl_d.ovw = bus_wdata[BIT_OVW_EN];
        end
        if (wr_en && hit.gen_ctl) ctl_d.cont = bus_wdata[BIT_CONT];
        if (cal_wr)   ctl_d.calf = 1'b0;
        if (done_cal) ctl_d.calf = conv_cal_fail;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.chan   <= '1;
            ctl_q.irq_en <= 1'b0;
            ctl_q.res    <= 2'b00;
            ctl_q.ovw    <= 1'b0;
            ctl_q.cont   <= 1'b0;
            ctl_q.calf   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            if (hit.chan_ctl) begin
                bus_rdata[CHAN_W-1:0] = ctl_q.chan;
                bus_rdata[BIT_IRQ_EN] = ctl_q.irq_en;
            end
            if (hit.status) bus_rdata[0] = res_flag;
            if (hit.result) bus_rdata[SAMPLE_W-1:0] = res_value;
            if (hit.config_r) begin
                bus_rdata[BIT_RES_LO +: 2] = ctl_q.res;
                bus_rdata[BIT_OVW_EN]      = ctl_q.ovw;
            end
            if (hit.gen_ctl) begin
                bus_rdata[BIT_CONT] = ctl_q.cont;
                bus_rdata[BIT_CAL]  = cal_active;
            end
            if (hit.gen_stat) bus_rdata[BIT_CAL_FAIL] = ctl_q.calf;
        end
    end

    assign conv_chan = ctl_q.chan;
    assign irq       = ctl_q.irq_en && res_flag;

endmodule

// File: rtl/adcfe_checker.sv
module adcfe_checker #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CHAN_W   = 5,
    parameter int SAMPLE_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_valid,
    input logic                bus_write,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [CHAN_W-1:0]   wr_chan,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                conv_start,
    input logic                cal_start,
    input logic [CHAN_W-1:0]   conv_chan,
    input logic                conv_active,
    input logic                cal_active,
    input logic                conv_done,
    input logic                irq,
    input logic                flag,
    input logic [SAMPLE_W-1:0] result,
    input logic                ovw
);

    logic chan_write, result_read, mapped;

    assign chan_write  = bus_valid && bus_write && (bus_addr == ADDR_W'('h00));
    assign result_read = bus_valid && !bus_write && (bus_addr == ADDR_W'('h0C));
    assign mapped = (bus_addr == ADDR_W'('h00)) || (bus_addr == ADDR_W'('h08)) ||
                    (bus_addr == ADDR_W'('h0C)) || (bus_addr == ADDR_W'('h14)) ||
                    (bus_addr == ADDR_W'('h18)) || (bus_addr == ADDR_W'('h1C));

    AST_LAUNCH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_write && wr_chan != '1) |=> (conv_start && conv_active && conv_chan == $past(wr_chan))); // R2

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_write && wr_chan == '1) |=> (!conv_start && !conv_active)); // R3

    AST_RESTART_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_write && wr_chan != '1 && conv_active) |=> (conv_start && conv_active)); // R4

    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (result_read && !conv_done) |=> (!flag && !irq)); // R6

    AST_HOLD_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && conv_active && !cal_active && flag && !ovw && !result_read && !chan_write)
        |=> (flag && $stable(result))); // R8

    AST_SINGLE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({conv_start, cal_start})); // R10

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !mapped) |-> (bus_rdata == '0)); // R11

endmodule

bind adc_ctrl_front adcfe_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CHAN_W   (CHAN_W),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .wr_chan     (bus_wdata[CHAN_W-1:0]),
    .bus_rdata   (bus_rdata),
    .conv_start  (conv_start),
    .cal_start   (cal_start),
    .conv_chan   (conv_chan),
    .conv_active (conv_active),
    .cal_active  (cal_active),
    .conv_done   (conv_done),
    .irq         (irq),
    .flag        (res_flag),
    .result      (res_value),
    .ovw         (ctl_q.ovw)
);

// File: tb/tb_adc_ctrl_front.sv
module tb_adc_ctrl_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        conv_start, cal_start, conv_active, irq;
    logic [4:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic        conv_cal_fail = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    adc_ctrl_front dut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_start(conv_start), .cal_start(cal_start), .conv_chan(conv_chan),
        .conv_active(conv_active), .conv_done(conv_done), .conv_data(conv_data),
        .conv_cal_fail(conv_cal_fail), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic done(input logic [11:0] s, input logic fail);
        @(negedge clk);
        conv_done = 1'b1; conv_data = s; conv_cal_fail = fail;
        @(negedge clk);
        conv_done = 1'b0; conv_cal_fail = 1'b0;
    endtask

    task automatic t_reset;
        rdreg(8'h00, rd); chk("R1 chan ctl", rd, 32'h1F);
        rdreg(8'h08, rd); chk("R1 status", rd, 0);
        rdreg(8'h18, rd); chk("R1 gen ctl", rd, 0);
        rdreg(8'h1C, rd); chk("R1 gen stat", rd, 0);
        chk("R1 outputs", {irq, conv_start, conv_active}, 0);
    endtask

    task automatic t_single;
        wr(8'h14, 32'h8);
        wr(8'h00, 32'h83);
        chk("R2 start pulse", {conv_start, conv_active}, 2'b11);
        chk("R2 channel", conv_chan, 3);
        @(negedge clk); chk("R2 pulse one cycle", conv_start, 0);
        done(12'hABC, 1'b0);
        rdreg(8'h08, rd); chk("R5 flag set", rd, 1);
        chk("R7 irq high", irq, 1);
        chk("R5 idle after done", conv_active, 0);
        rdreg(8'h0C, rd); chk("R5 result 12 bit", rd, 32'hABC);
        rdreg(8'h08, rd); chk("R6 flag cleared", rd, 0);
        chk("R6 irq low", irq, 0);
    endtask

    task automatic t_resolution;
        wr(8'h14, 32'h0); wr(8'h00, 32'h03); done(12'hABC, 1'b0);
        rdreg(8'h0C, rd); chk("R5 result 8 bit", rd, 32'hAB);
        wr(8'h14, 32'h4); wr(8'h00, 32'h03); done(12'hABC, 1'b0);
        rdreg(8'h0C, rd); chk("R5 result 10 bit", rd, 32'h2AF);
        wr(8'h14, 32'h8);
    endtask

    task automatic t_irq_off;
        wr(8'h00, 32'h04); done(12'h321, 1'b0);
        rdreg(8'h08, rd); chk("R7 flag without enable", rd, 1);
        chk("R7 irq masked", irq, 0);
        rdreg(8'h0C, rd); chk("R5 result", rd, 32'h321);
    endtask

    task automatic t_stop;
        wr(8'h00, 32'h02);
        wr(8'h00, 32'h1F);
        chk("R3 stop no launch", {conv_start, conv_active}, 0);
        done(12'h555, 1'b0);
        rdreg(8'h08, rd); chk("R3 flag untouched", rd, 0);
        rdreg(8'h0C, rd); chk("R3 result untouched", rd, 32'h321);
        done(12'h666, 1'b0);
        rdreg(8'h08, rd); chk("R3 idle done ignored", rd, 0);
    endtask

    task automatic t_restart;
        wr(8'h00, 32'h02);
        @(negedge clk);
        wr(8'h00, 32'h09);
        chk("R4 relaunch", {conv_start, conv_active}, 2'b11);
        chk("R4 new channel", conv_chan, 9);
        done(12'h9AB, 1'b0);
        rdreg(8'h0C, rd); chk("R4 result of new channel", rd, 32'h9AB);
    endtask

    task automatic t_overwrite;
        wr(8'h00, 32'h01); done(12'h111, 1'b0);
        wr(8'h00, 32'h01); done(12'h222, 1'b0);
        rdreg(8'h08, rd); chk("R8 flag kept", rd, 1);
        rdreg(8'h0C, rd); chk("R8 old result kept", rd, 32'h111);
        wr(8'h14, 32'h10008);
        wr(8'h00, 32'h01); done(12'h333, 1'b0);
        wr(8'h00, 32'h01); done(12'h444, 1'b0);
        rdreg(8'h0C, rd); chk("R8 result replaced", rd, 32'h444);
    endtask

    task automatic t_cont;
        wr(8'h18, 32'h40);
        wr(8'h00, 32'h06);
        done(12'h123, 1'b0);
        chk("R9 relaunch", {conv_start, conv_active}, 2'b11);
        chk("R9 same channel", conv_chan, 6);
        rdreg(8'h0C, rd); chk("R9 first result", rd, 32'h123);
        wr(8'h18, 32'h0);
        done(12'h456, 1'b0);
        chk("R9 stops after last", {conv_start, conv_active}, 0);
        rdreg(8'h0C, rd); chk("R9 last result", rd, 32'h456);
    endtask

    task automatic t_cal;
        wr(8'h00, 32'h9F);
        wr(8'h18, 32'h80);
        chk("R10 cal launch", {cal_start, conv_start, conv_active}, 3'b101);
        rdreg(8'h18, rd); chk("R10 busy bit", rd, 32'h80);
        done(12'h0, 1'b1);
        rdreg(8'h1C, rd); chk("R10 fail reported", rd, 32'h2);
        rdreg(8'h08, rd); chk("R10 completion flag", rd, 1);
        chk("R10 irq", irq, 1);
        rdreg(8'h18, rd); chk("R10 busy bit clear", rd, 0);
        rdreg(8'h0C, rd);
        chk("R6 irq cleared", irq, 0);
        wr(8'h18, 32'h80);
        rdreg(8'h1C, rd); chk("R10 fail cleared on start", rd, 0);
        done(12'h0, 1'b0);
        rdreg(8'h1C, rd); chk("R10 pass reported", rd, 0);
        rdreg(8'h0C, rd);
    endtask

    task automatic t_unmapped;
        wr(8'h04, 32'hFFFF_FFFF);
        rdreg(8'h04, rd); chk("R11 hole reads zero", rd, 0);
        rdreg(8'h20, rd); chk("R11 past end reads zero", rd, 0);
        wr(8'h15, 32'hFFFF_FFFF);
        rdreg(8'h15, rd); chk("R11 misaligned reads zero", rd, 0);
        rdreg(8'h14, rd); chk("R11 config unchanged", rd, 32'h10008);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_single;
        t_resolution;
        t_irq_off;
        t_stop;
        t_restart;
        t_overwrite;
        t_cont;
        t_cal;
        t_unmapped;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule